// File: doc/BRIEF.md
# SD Command Line Transceiver

This block owns the single bidirectional command wire between an SD host and a card. A controller presents a 6-bit command index and a 32-bit argument with a one-cycle valid strobe. The block builds a 48-bit frame, appends a CRC7, and shifts the frame out one bit per clock. It drives the output enable only while it transmits. After the end bit it releases the line and waits for the card's reply.

Each command says which kind of reply to expect. A short reply is 48 bits and yields an index and an argument. A long reply is 136 bits and carries a 128-bit identification register, which the block splits into its fields. The block can also skip the reply CRC check for a command; the operating-conditions reply has no valid CRC and needs this. A one-cycle acknowledge comes while the end bit is still on the wire, so the controller can stage its next command early. A receiving flag, a valid pulse and an error pulse report the progress of each reply.

Top module: `sd_cmd_line`

## Requirements
- R1: When `cmd_valid` is high in idle, the frame leaves on `line_out` from the next cycle, one bit per clock, MSB first. The 48 bits are: a start bit 0, a direction bit 1, the index (6 bits), the argument (32 bits), the CRC7 (7 bits), and an end bit 1. While a command is in progress, `cmd_valid` is ignored.
- R2: The CRC7 uses polynomial x^7+x^3+1 with a zero start value. It is fed MSB first with the first 40 frame bits: start, direction, index and argument.
- R3: `line_oe` is high for exactly the 48 frame cycles and low at all other times. While it is low, `line_out` reads 1.
- R4: `ack` is high for exactly one cycle per command. That cycle is the one in which the end bit is driven, right after the last CRC bit.
- R5: `line_in` is ignored in idle and while transmitting. A low level in those states starts no reply.
- R6: `rx_active` goes high in the cycle after the start bit is sampled. It stays high until the last reply bit has been sampled.
- R7: A short reply is 48 bits: start 0, direction 0, index, argument, CRC7 over the first 40 bits, end 1. If it is intact, `rx_valid` pulses for one cycle and `rx_index`/`rx_arg` take the received values.
- R8: If `check_crc` was set with the command and the reply CRC does not match, `rx_err` pulses for one cycle instead of `rx_valid`. The captured outputs then keep their old values.
- R9: If `check_crc` was clear with the command, a reply with a wrong CRC is still accepted, with an `rx_valid` pulse.
- R10: With `expect_long` set, the reply is 136 bits: start 0, direction 0, index field 6'h3F, and ID bits 127:1, whose bit 0 is the end bit. The CRC7 is taken over ID bits 127:8 and compared with bits 7:1. The fields are mapped as follows:
  - `id_mid` is bits 127:120
  - `id_oid` is bits 119:104
  - `id_name` is bits 103:64
  - `id_rev` is bits 63:56
  - `id_serial` is bits 55:24
  - `id_date` is bits 19:8
- R11: After the end bit, the line is sampled for at most RESP_TIMEOUT (64) cycles. A start bit on the 64th sample is still accepted. If no start bit has come by then, `rx_err` pulses and the block returns to idle.
- R12: A reply whose direction bit is 1, or whose end bit is 0, ends with `rx_err` and no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Start a command (taken in idle) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| expect_long | input | 1 | Reply is a 136-bit ID reply |
| check_crc | input | 1 | Verify the reply CRC |
| line_in | input | 1 | Sampled command line |
| line_out | output | 1 | Driven command line value |
| line_oe | output | 1 | Output enable for the line |
| ack | output | 1 | End bit being driven; next command may be staged |
| rx_active | output | 1 | Reply being shifted in |
| rx_valid | output | 1 | Intact reply received |
| rx_err | output | 1 | Reply failed or timed out |
| rx_index | output | 6 | Received short-reply index |
| rx_arg | output | 32 | Received short-reply argument |
| id_mid | output | 8 | ID manufacturer field |
| id_oid | output | 16 | ID OEM field |
| id_name | output | 40 | ID product name field |
| id_rev | output | 8 | ID revision field |
| id_serial | output | 32 | ID serial number field |
| id_date | output | 12 | ID date field |

## Verification
The hardest case to reach is the edge of the reply window. A start bit that arrives on the very last allowed sample must be accepted. One that never arrives must give an error on that same sample. To reach this edge, the bench counts negative edges from the moment the output enable drops. It then holds the line high for exactly 63 cycles before driving the start bit, and for 64 cycles in the timeout case. Long replies with a deliberately flipped CRC bit, and short replies with the CRC bypass set, cover the two CRC paths.

// File: rtl/sd_cmd_line.sv
module sd_cmd_line #(
  parameter int RESP_TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [5:0]  cmd_index,
  input  logic [31:0] cmd_arg,
  input  logic        expect_long,
  input  logic        check_crc,
  input  logic        line_in,
  output logic        line_out,
  output logic        line_oe,
  output logic        ack,
  output logic        rx_active,
  output logic        rx_valid,
  output logic        rx_err,
  output logic [5:0]  rx_index,
  output logic [31:0] rx_arg,
  output logic [7:0]  id_mid,
  output logic [15:0] id_oid,
  output logic [39:0] id_name,
  output logic [7:0]  id_rev,
  output logic [31:0] id_serial,
  output logic [11:0] id_date
);
  localparam int SHORT_LEN = 48;
  localparam int LONG_LEN  = 136;
  localparam int CNT_MAX   = (RESP_TIMEOUT > LONG_LEN) ? RESP_TIMEOUT : LONG_LEN;
  localparam int CW        = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_WAIT, S_RX} state_t;

  state_t                state;
  logic [CW-1:0]         cnt;
  logic [SHORT_LEN-1:0]  tx_sr;
  logic [LONG_LEN-1:0]   rx_sr;
  logic                  long_q, chk_q;

  function automatic logic [6:0] crc7(input logic [119:0] d, input int n);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = 0; i < 120; i++) begin
      if (i < n) begin
        fb = d[119-i] ^ c[6];
        c  = {c[5:0], 1'b0};
        if (fb) c = c ^ 7'h09;
      end
    end
    return c;
  endfunction

  logic [39:0]         tx_body;
  logic [6:0]          tx_crc;
  logic [LONG_LEN-1:0] rx_next;
  logic                short_ok, long_ok, rx_ok, last_bit;

  assign tx_body = {1'b0, 1'b1, cmd_index, cmd_arg};
  assign tx_crc  = crc7({tx_body, 80'b0}, 40);
  assign rx_next = {rx_sr[LONG_LEN-2:0], line_in};

  assign short_ok = !rx_next[46] && rx_next[0] &&
                    (!chk_q || crc7({rx_next[47:8], 80'b0}, 40) == rx_next[7:1]);
  assign long_ok  = !rx_next[134] && rx_next[0] && (rx_next[133:128] == 6'h3F) &&
                    (!chk_q || crc7(rx_next[127:8], 120) == rx_next[7:1]);
  assign rx_ok    = long_q ? long_ok : short_ok;
  assign last_bit = long_q ? (cnt == CW'(LONG_LEN - 1)) : (cnt == CW'(SHORT_LEN - 1));

  assign line_oe   = (state == S_TX);
  assign line_out  = line_oe ? tx_sr[SHORT_LEN-1] : 1'b1;
  assign ack       = line_oe && (cnt == CW'(SHORT_LEN - 1));
  assign rx_active = (state == S_RX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      tx_sr     <= '0;
      rx_sr     <= '0;
      long_q    <= 1'b0;
      chk_q     <= 1'b0;
      rx_valid  <= 1'b0;
      rx_err    <= 1'b0;
      rx_index  <= '0;
      rx_arg    <= '0;
      id_mid    <= '0;
      id_oid    <= '0;
      id_name   <= '0;
      id_rev    <= '0;
      id_serial <= '0;
      id_date   <= '0;
    end else begin
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            tx_sr  <= {tx_body, tx_crc, 1'b1};
            cnt    <= '0;
            long_q <= expect_long;
            chk_q  <= check_crc;
            state  <= S_TX;
          end
        end
        S_TX: begin
          tx_sr <= {tx_sr[SHORT_LEN-2:0], 1'b0};
          if (cnt == CW'(SHORT_LEN - 1)) begin
            cnt   <= '0;
            state <= S_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (!line_in) begin
            rx_sr <= '0;
            cnt   <= CW'(1);
            state <= S_RX;
          end else if (cnt == CW'(RESP_TIMEOUT - 1)) begin
            rx_err <= 1'b1;
            cnt    <= '0;
            state  <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RX: begin
          rx_sr <= rx_next;
          if (last_bit) begin
            cnt   <= '0;
            state <= S_IDLE;
            if (rx_ok) begin
              rx_valid <= 1'b1;
              if (long_q) begin
                id_mid    <= rx_next[127:120];
                id_oid    <= rx_next[119:104];
                id_name   <= rx_next[103:64];
                id_rev    <= rx_next[63:56];
                id_serial <= rx_next[55:24];
                id_date   <= rx_next[19:8];
              end else begin
                rx_index <= rx_next[45:40];
                rx_arg   <= rx_next[39:8];
              end
            end else begin
              rx_err <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_cmd_line_chk.sv
module sd_cmd_line_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic line_out,
  input logic line_oe,
  input logic ack,
  input logic rx_active,
  input logic rx_valid,
  input logic rx_err
);
  localparam int FRAME_LEN = 48;
  logic [7:0] oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       oe_run <= '0;
    else if (line_oe) oe_run <= oe_run + 8'd1;
    else              oe_run <= '0;
  end

  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> !line_out);
  a_r1_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> $past(cmd_valid));
  a_r3_oe_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> (oe_run == 8'(FRAME_LEN)));
  a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> line_out);
  a_r4_ack_end_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (line_oe && line_out));
  a_r4_ack_last: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !line_oe);
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_oe && rx_active));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_err));
  a_r7_valid_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_active));
endmodule

bind sd_cmd_line sd_cmd_line_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .line_out(line_out),
  .line_oe(line_oe), .ack(ack), .rx_active(rx_active),
  .rx_valid(rx_valid), .rx_err(rx_err)
);

// File: tb/tb_sd_cmd_line.sv
`timescale 1ns/1ps
module tb_sd_cmd_line;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, expect_long = 1'b0, check_crc = 1'b1, line_in = 1'b1;
  logic [5:0] cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic line_out, line_oe, ack, rx_active, rx_valid, rx_err;
  logic [5:0] rx_index;
  logic [31:0] rx_arg, id_serial;
  logic [7:0] id_mid, id_rev;
  logic [15:0] id_oid;
  logic [39:0] id_name;
  logic [11:0] id_date;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sd_cmd_line dut (.*);

  task automatic chk(input string req, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [119:0] msg, input int nbits);
    logic [6:0] r = '0;
    logic b;
    for (int k = nbits - 1; k >= 0; k--) begin
      b = msg[k] ^ r[6];
      r = {r[5], r[4], r[3], r[2] ^ b, r[1], r[0], b};
    end
    return r;
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] arg,
                                            input logic [6:0] flip, input logic dirb, input logic endb);
    logic [6:0] c = ref_crc({80'b0, 1'b0, dirb, idx, arg}, 40) ^ flip;
    return {88'b0, 1'b0, dirb, idx, arg, c, endb};
  endfunction

  function automatic logic [135:0] mk_long(input logic [119:0] hi, input logic [6:0] flip);
    logic [6:0] c = ref_crc(hi, 120) ^ flip;
    return {2'b00, 6'h3F, hi, c, 1'b1};
  endfunction

  // Sends a command and checks the frame, output enable and acknowledge (R1-R4).
  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic lng,
                       input logic chkc, input logic low_line);
    logic [47:0] cap = '0, exp;
    int oe_n = 0, ack_n = 0, ack_at = -1;
    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; expect_long = lng; check_crc = chkc; cmd_valid = 1'b1;
    if (low_line) line_in = 1'b0;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (i == 0) cmd_valid = 1'b0;
      if (i == 3) begin cmd_valid = 1'b1; cmd_index = ~idx; end
      if (i == 4) cmd_valid = 1'b0;
      cap = {cap[46:0], line_out};
      if (line_oe) oe_n++;
      if (ack) begin ack_n++; ack_at = i; end
      if (i == 47) line_in = 1'b1;
    end
    exp = {2'b01, idx, arg, ref_crc({80'b0, 2'b01, idx, arg}, 40), 1'b1};
    chk("R1 frame", cap, exp);
    chk("R2 crc", cap[7:1], ref_crc({80'b0, exp[47:8]}, 40));
    chk("R3 oe cycles", oe_n, 48);
    chk("R4 ack count", ack_n, 1);
    chk("R4 ack position", ack_at, 47);
    @(negedge clk);
    chk("R3 oe low after end", {line_oe, line_out}, 2'b01);
    chk("R5 no rx during tx", rx_active, 0);
  endtask

  task automatic respond(input logic [135:0] fr, input int n, input int dly);
    int act_n = 0;
    repeat (dly) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      line_in = fr[n-1-i];
      @(negedge clk);
      if (i < n - 1 && rx_active) act_n++;
    end
    line_in = 1'b1;
    chk("R6 rx_active span", act_n, n - 1);
    chk("R6 rx_active drops", rx_active, 0);
  endtask

  task automatic t_reset;
    chk("R3 reset outputs", {line_oe, line_out, ack, rx_active, rx_valid, rx_err}, 6'b010000);
  endtask

  task automatic t_short_ok;
    issue(6'd17, 32'h1234_5678, 0, 1, 1);
    respond(mk_short(6'd17, 32'hA5A5_0F0F, 0, 0, 1), 48, 3);
    chk("R7 valid", {rx_valid, rx_err}, 2'b10);
    chk("R7 index", rx_index, 6'd17);
    chk("R7 arg", rx_arg, 32'hA5A5_0F0F);
    @(negedge clk);
    chk("R7 valid one cycle", rx_valid, 0);
  endtask

  task automatic t_cmd0_timeout;
    issue(6'd0, 32'h0, 0, 1, 0);
    chk("R2 known crc", ref_crc(120'h40_0000_0000, 40), 7'h4A);
    repeat (63) @(negedge clk);
    chk("R11 no early error", rx_err, 0);
    @(negedge clk);
    chk("R11 timeout error", {rx_valid, rx_err}, 2'b01);
  endtask

  task automatic t_bad_crc;
    issue(6'd13, 32'hDEAD_0001, 0, 1, 0);
    respond(mk_short(6'd13, 32'h0BAD_0BAD, 7'h01, 0, 1), 48, 0);
    chk("R8 crc error", {rx_valid, rx_err}, 2'b01);
    chk("R8 arg kept", rx_arg, 32'hA5A5_0F0F);
  endtask

  task automatic t_bypass;
    issue(6'd41, 32'h40FF_8000, 0, 0, 0);
    respond(mk_short(6'h3F, 32'hC0FF_8000, 7'h55, 0, 1), 48, 5);
    chk("R9 bypass valid", {rx_valid, rx_err}, 2'b10);
    chk("R9 bypass arg", rx_arg, 32'hC0FF_8000);
  endtask

  task automatic t_long(input logic [6:0] flip);
    logic [119:0] hi = {8'h1B, 16'h534D, 40'h4150_5047_34, 8'h21, 32'h9876_5432, 4'h0, 12'h0A3};
    issue(6'd2, 32'h0, 1, 1, 0);
    respond(mk_long(hi, flip), 136, 2);
    if (flip == 0) begin
      chk("R10 long valid", {rx_valid, rx_err}, 2'b10);
      chk("R10 fields", {id_mid, id_oid, id_name, id_rev, id_serial, id_date},
          {8'h1B, 16'h534D, 40'h4150_5047_34, 8'h21, 32'h9876_5432, 12'h0A3});
    end else begin
      chk("R10 long crc error", {rx_valid, rx_err}, 2'b01);
      chk("R10 fields kept", id_serial, 32'h9876_5432);
    end
  endtask

  task automatic t_late_start;
    issue(6'd7, 32'h0001_0000, 0, 1, 0);
    respond(mk_short(6'd7, 32'h0000_0900, 0, 0, 1), 48, 63);
    chk("R11 last-sample start accepted", {rx_valid, rx_err}, 2'b10);
  endtask

  task automatic t_framing;
    issue(6'd9, 32'h0, 0, 1, 0);
    respond(mk_short(6'd9, 32'h1, 0, 0, 0), 48, 1);
    chk("R12 end bit error", {rx_valid, rx_err}, 2'b01);
    issue(6'd9, 32'h0, 0, 1, 0);
    respond(mk_short(6'd9, 32'h2, 0, 1, 1), 48, 1);
    chk("R12 dir bit error", {rx_valid, rx_err}, 2'b01);
  endtask

  task automatic t_idle_low;
    int seen = 0;
    @(negedge clk);
    line_in = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (rx_active || rx_valid || rx_err || line_oe) seen++;
    end
    line_in = 1'b1;
    chk("R5 idle low ignored", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_short_ok();
    t_cmd0_timeout();
    t_bad_crc();
    t_bypass();
    t_long(7'h00);
    t_long(7'h10);
    t_late_start();
    t_framing();
    t_idle_low();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule